// File: doc/BRIEF.md
# Index pulse and MSB marker generator

This block drives the Z pin of an incremental interpolator. It reads the core angle step, the rotation direction, the resolution setting and the next quadrature state (the values the A/B stage will load on the coming clock edge). From these it forms a reference-mark pulse once per input signal cycle. The pulse covers exactly the quarter of the A/B period in which both A and B are high and which holds the core zero step. It reaches Z only while an external zero-enable comparator bit is true.

A three-level phase select picks the Z function. Codes 2'b00 (lo), 2'b10 (hi) and 2'b11 (treated as hi) give the gated index pulse. Code 2'b01 (open) replaces the index with the most significant bit of the angle measured from the zero step. That bit is high for the half of the input cycle that starts at the zero step, and it is meant for aligning coarse absolute tracks. Z is registered, so it changes on the same edge as A and B.

Four enumerated states control the index function:
- ST_WAIT: waiting for the window.
- ST_PULSE: Z high.
- ST_SPENT: the pulse for this window has been used up or cut short.
- ST_MSB: marker mode.

The state moves as follows:
- From any state, an open select goes to ST_MSB.
- ST_MSB goes to ST_SPENT when the select leaves open inside the window, and to ST_WAIT when it leaves open outside it.
- ST_WAIT goes to ST_PULSE when the window and the enable are both true.
- ST_PULSE goes to ST_WAIT when the window ends, and to ST_SPENT when the enable drops.
- ST_SPENT goes to ST_WAIT when the window ends.
- In every other case the state holds.

Top module: `zmark_gen`

## Requirements
- R1: While reset is asserted Z is 0, and Z is still 0 on the first clock after release.
- R2: In index mode with the enable true, Z is 1 in the cycle after every edge at which a_nxt=b_nxt=1 and the effective angle lies in the window, and it is 0 after every edge at which that does not hold.
- R3: After the pulse has been cut short by the enable falling, Z stays 0 for the rest of that window even if the enable returns, so there is at most one pulse per window.
- R4: In index mode Z is 1 only after an edge at which zero_en was 1, and Z falls on the first edge at which zero_en is 0.
- R5: In index mode Z is 1 only after an edge at which a_nxt and b_nxt were both 1.
- R6: The window is the set of effective angles e for which (e >> s) equals (ZERO_POS >> s). Here s is res_sel, clamped to ANG_W-2, and 2^s is the A/B quarter period in core steps. Setting 0 gives a one-step window and setting 4 (with 64 steps) gives a 16-step window.
- R7: The effective angle is step_ang + HYST_STEPS modulo 2^ANG_W when dir_neg is 1, and step_ang when dir_neg is 0. This shifts the window down by HYST_STEPS in the negative direction.
- R8: With phase_sel=2'b01, Z is loaded with 1 when (step_ang - ZERO_POS) modulo 2^ANG_W is below 2^(ANG_W-1), and with 0 otherwise, regardless of zero_en.
- R9: phase_sel values 2'b00, 2'b10 and 2'b11 all select index mode, with identical behaviour.
- R10: When the select leaves 2'b01 while the angle is inside the window, no pulse is produced until the window has been left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_ang | input | ANG_W | Core angle step that the A/B stage loads at the next edge |
| dir_neg | input | 1 | 1 when rotating in the negative direction |
| res_sel | input | SEL_W | Resolution setting; 2^res_sel core steps per A/B quarter |
| a_nxt | input | 1 | Next value of quadrature output A |
| b_nxt | input | 1 | Next value of quadrature output B |
| zero_en | input | 1 | Zero-enable comparator bit |
| phase_sel | input | 2 | Z function select: 00 lo, 01 open (marker), 10 hi, 11 as hi |
| z_o | output | 1 | Registered Z output |

## Verification
The assertions assume that a_nxt and b_nxt match the angle: within each A/B period of four quarters, both are 1 only in the quarter that the angle places there. The enable, gating and A/B checks also read the previous cycle's inputs through $past, so they rely on inputs being stable around the clock edge. The stimulus produces A and B with a bench quadrature function of the angle, the direction and the clamped setting, and it drives every input half a cycle before the edge. The angle walk moves by at most one step per cycle, which is how a real core advances, while the enable, select and setting change freely.

// File: rtl/zmark_pkg.sv
package zmark_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_PULSE = 2'd1,
        ST_SPENT = 2'd2,
        ST_MSB   = 2'd3
    } zmark_state_t;

    localparam logic [1:0] PH_LO   = 2'b00;
    localparam logic [1:0] PH_OPEN = 2'b01;
    localparam logic [1:0] PH_HI   = 2'b10;

endpackage

// File: rtl/zmark_window.sv
module zmark_window #(
    parameter int ANG_W      = 6,
    parameter int SEL_W      = 3,
    parameter int ZERO_POS   = 8,
    parameter int HYST_STEPS = 1
) (
    input  logic [ANG_W-1:0] step_ang,
    input  logic             dir_neg,
    input  logic [SEL_W-1:0] res_sel,
    input  logic             a_nxt,
    input  logic             b_nxt,
    output logic             in_win
);
    // one setting per quarter width, from 1 step up to a quarter cycle
    localparam int NSET = ANG_W - 1;
    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NSET - 1);

    logic [ANG_W-1:0] ang_eff;
    logic [NSET-1:0]  per_hit;
    logic [SEL_W-1:0] sel_c;

    // negative direction lags by the hysteresis offset
    assign ang_eff = dir_neg ? (step_ang + ANG_W'(HYST_STEPS)) : step_ang;
    assign sel_c   = (res_sel > SEL_MAX) ? SEL_MAX : res_sel;

    // a full A/B period spans 4 quarters of 2^g steps
    for (genvar g = 0; g < NSET; g++) begin : g_period
        localparam int SH = g + 2;
        assign per_hit[g] = ((ang_eff >> SH) == ANG_W'(ZERO_POS >> SH));
    end

    assign in_win = a_nxt && b_nxt && per_hit[sel_c];

endmodule

// File: rtl/zmark_msb.sv
module zmark_msb #(
    parameter int ANG_W    = 6,
    parameter int ZERO_POS = 8
) (
    input  logic [ANG_W-1:0] step_ang,
    output logic             msb_bit
);
    logic [ANG_W-1:0] rel_ang;

    assign rel_ang = step_ang - ANG_W'(ZERO_POS);
    assign msb_bit = ~rel_ang[ANG_W-1];

endmodule

// File: rtl/zmark_fsm.sv
module zmark_fsm
    import zmark_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_win,
    input  logic zero_en,
    input  logic msb_mode,
    input  logic msb_bit,
    input  logic ab_both,
    output logic z_q
);
    zmark_state_t state_q, state_d;
    logic         z_d;

    always_comb begin
        state_d = state_q;
        if (msb_mode) begin
            state_d = ST_MSB;
        end else begin
            unique case (state_q)
                ST_MSB:   state_d = in_win ? ST_SPENT : ST_WAIT;
                ST_WAIT:  state_d = (in_win && zero_en) ? ST_PULSE : ST_WAIT;
                ST_PULSE: begin
                    if (!in_win)       state_d = ST_WAIT;
                    else if (!zero_en) state_d = ST_SPENT;
                    else               state_d = ST_PULSE;
                end
                ST_SPENT: state_d = in_win ? ST_SPENT : ST_WAIT;
            endcase
        end
    end

    always_comb begin
        z_d = (state_d == ST_PULSE) || ((state_d == ST_MSB) && msb_bit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) z_q <= 1'b0;
        else        z_q <= z_d;
    end

    AST_PULSE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (z_q && state_q != ST_MSB) |-> $past(zero_en)); // R4

    AST_PULSE_ON_AB: assert property (@(posedge clk) disable iff (!rst_n)
        (z_q && state_q != ST_MSB) |-> $past(ab_both)); // R5

    AST_NO_REPULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPENT && !msb_mode && in_win) |=> !z_q); // R3

endmodule

// File: rtl/zmark_gen.sv
module zmark_gen
    import zmark_pkg::*;
#(
    parameter int ANG_W      = 6,
    parameter int SEL_W      = 3,
    parameter int ZERO_POS   = 8,
    parameter int HYST_STEPS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ANG_W-1:0] step_ang,
    input  logic             dir_neg,
    input  logic [SEL_W-1:0] res_sel,
    input  logic             a_nxt,
    input  logic             b_nxt,
    input  logic             zero_en,
    input  logic [1:0]       phase_sel,
    output logic             z_o
);
    logic in_win;
    logic msb_bit;
    logic msb_mode;

    assign msb_mode = (phase_sel == PH_OPEN);

    zmark_window #(
        .ANG_W(ANG_W), .SEL_W(SEL_W),
        .ZERO_POS(ZERO_POS), .HYST_STEPS(HYST_STEPS)
    ) win_i (
        .step_ang(step_ang), .dir_neg(dir_neg), .res_sel(res_sel),
        .a_nxt(a_nxt), .b_nxt(b_nxt), .in_win(in_win)
    );

    zmark_msb #(.ANG_W(ANG_W), .ZERO_POS(ZERO_POS)) msb_i (
        .step_ang(step_ang), .msb_bit(msb_bit)
    );

    zmark_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .in_win(in_win), .zero_en(zero_en),
        .msb_mode(msb_mode), .msb_bit(msb_bit),
        .ab_both(a_nxt & b_nxt), .z_q(z_o)
    );

    AST_RESET_LOW: assert property (@(posedge clk)
        $rose(rst_n) |-> !z_o); // R1

    AST_MSB_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_sel == PH_OPEN) |=> (z_o == $past(msb_bit))); // R8

endmodule

// File: tb/zmark_gen_tb.sv
module zmark_gen_tb_top;
    localparam int AW = 6;
    localparam int SW = 3;
    localparam int ZP = 8;
    localparam int HY = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] step_ang = '0;
    logic          dir_neg = 1'b0;
    logic [SW-1:0] res_sel = '0;
    logic          a_nxt = 1'b0;
    logic          b_nxt = 1'b0;
    logic          zero_en = 1'b0;
    logic [1:0]    phase_sel = 2'b00;
    logic          z_o;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    bit m_pulse = 0, m_spent = 0, m_msb = 0, exp_z = 0;

    always #2 clk = ~clk;

    zmark_gen #(.ANG_W(AW), .SEL_W(SW), .ZERO_POS(ZP), .HYST_STEPS(HY)) dut_i (
        .clk(clk), .rst_n(rst_n), .step_ang(step_ang), .dir_neg(dir_neg),
        .res_sel(res_sel), .a_nxt(a_nxt), .b_nxt(b_nxt), .zero_en(zero_en),
        .phase_sel(phase_sel), .z_o(z_o)
    );

    function automatic int clamp_sel(input int s);
        return (s > AW - 2) ? AW - 2 : s;
    endfunction

    function automatic int eff_ang(input int ang, input bit neg);
        return (ang + (neg ? HY : 0)) % (1 << AW);
    endfunction

    // quadrant of the effective angle relative to the zero quadrant
    function automatic int quad_rel(input int ang, input bit neg, input int sel);
        int s = clamp_sel(sel);
        return ((eff_ang(ang, neg) >> s) - (ZP >> s)) & 3;
    endfunction

    function automatic bit ref_win(input int ang, input bit neg, input int sel);
        int s = clamp_sel(sel);
        return (eff_ang(ang, neg) >> s) == (ZP >> s);
    endfunction

    function automatic bit ref_msb(input int ang);
        return (((ang - ZP) + (1 << AW)) % (1 << AW)) < (1 << (AW - 1));
    endfunction

    task automatic check_z();
        n_chk++;
        if (z_o !== exp_z) begin
            n_bad++;
            $display("FAIL %s: z=%0b expected %0b at angle %0d", cur_req, z_o, exp_z, step_ang);
        end
    endtask

    task automatic step(input int ang, input bit neg, input int sel,
                        input bit en, input logic [1:0] ph);
        int  q;
        bit  w;
        @(negedge clk);
        check_z();
        q = quad_rel(ang, neg, sel);
        step_ang  = AW'(ang);
        dir_neg   = neg;
        res_sel   = SW'(sel);
        a_nxt     = (q == 0) || (q == 1);
        b_nxt     = (q == 0) || (q == 3);
        zero_en   = en;
        phase_sel = ph;
        w = ref_win(ang, neg, sel);
        if (ph == 2'b01) begin
            m_msb = 1; m_pulse = 0; m_spent = 0;
            exp_z = ref_msb(ang);
        end else begin
            if (m_msb) begin
                m_msb = 0; m_pulse = 0; m_spent = w;
            end else if (m_pulse) begin
                if (!w)       begin m_pulse = 0; m_spent = 0; end
                else if (!en) begin m_pulse = 0; m_spent = 1; end
            end else if (m_spent) begin
                if (!w) m_spent = 0;
            end else if (w && en) begin
                m_pulse = 1;
            end
            exp_z = m_pulse;
        end
    endtask

    task automatic sweep(input int start, input int cnt, input int inc, input bit neg,
                         input int sel, input bit en, input logic [1:0] ph);
        for (int i = 0; i < cnt; i++)
            step(((start + i * inc) % 64 + 64) % 64, neg, sel, en, ph);
    endtask

    initial begin
        int ang;
        int sel;
        void'($urandom(32'd20240613));
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check_z();
        rst_n = 1'b1;
        step(0, 0, 0, 0, 2'b00);
        step(0, 0, 0, 0, 2'b00);

        cur_req = "R2";
        sweep(0, 130, 1, 0, 4, 1, 2'b00);

        cur_req = "R6";
        sweep(0, 70, 1, 0, 0, 1, 2'b00);
        sweep(0, 70, 1, 0, 2, 1, 2'b00);
        sweep(0, 70, 1, 0, 7, 1, 2'b00);

        cur_req = "R7";
        sweep(63, 130, -1, 1, 0, 1, 2'b00);
        sweep(63, 70, -1, 1, 3, 1, 2'b00);

        cur_req = "R4";
        sweep(0, 70, 1, 0, 4, 0, 2'b00);
        for (int i = 0; i < 16; i++) step(i, 0, 4, (i % 3) != 2, 2'b00);

        cur_req = "R3";
        sweep(20, 44, 1, 0, 4, 1, 2'b00);
        for (int i = 0; i < 4; i++) step(i, 0, 4, 1, 2'b00);
        step(4, 0, 4, 0, 2'b00);
        for (int i = 0; i < 6; i++) step(5, 0, 4, 1, 2'b00);
        for (int i = 6; i < 20; i++) step(i, 0, 4, 1, 2'b00);

        cur_req = "R8";
        sweep(0, 70, 1, 0, 2, 0, 2'b01);
        sweep(63, 70, -1, 1, 4, 1, 2'b01);

        cur_req = "R9";
        sweep(0, 70, 1, 0, 4, 1, 2'b10);
        sweep(0, 70, 1, 0, 1, 1, 2'b11);

        cur_req = "R10";
        sweep(0, 4, 1, 0, 4, 1, 2'b01);
        for (int i = 4; i < 20; i++) step(i, 0, 4, 1, 2'b00);
        sweep(20, 70, 1, 0, 4, 1, 2'b00);

        cur_req = "R5";
        ang = 0;
        sel = 0;
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [1:0] ph;
            if (i % 250 == 0) sel = int'($urandom_range(0, 7));
            r = int'($urandom_range(0, 3));
            if (r == 1) ang = (ang + 1) % 64;
            if (r == 2) ang = (ang + 63) % 64;
            r = int'($urandom_range(0, 19));
            ph = (r == 0) ? 2'b01 : ((r < 10) ? 2'b00 : 2'b10);
            step(ang, ($urandom_range(0, 1) == 1), sel, ($urandom_range(0, 7) != 0), ph);
        end
        @(negedge clk);
        check_z();

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule